// File: doc/BRIEF.md
# External Interrupt Pin Detector

This block watches one external interrupt pin and turns activity on it into a sticky event flag. Software controls it through a single 8-bit status/control register on a simple write strobe plus read-data bus. The register sets the active polarity, chooses between edge-only and edge-plus-level detection, turns the pin function on, and enables the interrupt request. It also reports the event flag and takes a write-one acknowledge.

The pin is brought into the clock domain through a chain of flip-flops. An event is the move from the inactive to the active level between two consecutive synchronised samples. In level mode, an active level also counts as an event on every cycle. The block drives an interrupt request line and two pull-device select outputs. The selected pull device opposes the chosen polarity: pull-up when falling edges are watched, pull-down when rising edges are watched.

Top module: `extirq_detect`

## Requirements
- R1: After reset, reg_rdata reads 0x00, and irq_req, pull_up_en and pull_dn_en are all 0.
- R2: Register bit map: 6 pull disable, 5 rising polarity, 4 pin enable, 3 event flag, 2 acknowledge, 1 interrupt enable, 0 level mode. A write stores bits 6, 5, 4, 1 and 0. Bit 7 and bit 2 always read 0. Writes to bits 7 and 3 have no effect.
- R3: With the default two-stage synchroniser, a qualifying pin change first shows as a set flag after the third rising clock edge that follows the change.
- R4: With bit 5 at 0, falling edges (and low levels in level mode) are events. With bit 5 at 1, rising edges (and high levels) are events. Transitions of the opposite direction never set the flag.
- R5: With bit 0 at 0, only a transition sets the flag. A pin held at the active level after an acknowledge leaves the flag clear.
- R6: With bit 0 at 1, the active level sets the flag on every cycle. An acknowledge cannot clear it while the synchronised pin stays active, and it clears once the pin is inactive.
- R7: A register write with bit 2 at 1 clears the flag when no event occurs in that cycle. A write with bit 2 at 0 leaves the flag unchanged.
- R8: When an event and an acknowledge happen in the same cycle, the flag ends up set.
- R9: irq_req is 1 exactly when the flag and the interrupt enable (bit 1) are both 1.
- R10: With pin enable (bit 4) at 0, no pin activity sets the flag.
- R11: pull_up_en is 1 when bit 4 is 1, bit 6 is 0 and bit 5 is 0. pull_dn_en is 1 when bit 4 is 1, bit 6 is 0 and bit 5 is 1. Otherwise both are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | 1 | Raw external interrupt pin level |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Current register read value |
| irq_req | output | 1 | Interrupt request to the processor |
| pull_up_en | output | 1 | Turns on the pin pull-up device |
| pull_dn_en | output | 1 | Turns on the pin pull-down device |

## Verification
The hardest case to reach from the ports is an acknowledge that lands in the same clock cycle as a new edge leaving the synchroniser. The pin change has to lead the acknowledge write by exactly the synchroniser depth. A directed sequence first clears the flag. It then drives the pin inactive long enough to settle, moves it to the active level, and issues the acknowledge write on the third cycle, so that the flag must stay set. The level-mode lock-out is also forced directly: acknowledges are issued while the pin is held active and again after it returns inactive. Long random stretches of pin activity and register writes cover the rest, compared every cycle against a model in the bench.

// File: rtl/extirq_pkg.sv
`timescale 1ns/1ps
package extirq_pkg;
   localparam int REG_W  = 8;
   localparam int B_MODE = 0;
   localparam int B_IE   = 1;
   localparam int B_ACK  = 2;
   localparam int B_FLAG = 3;
   localparam int B_PEN  = 4;
   localparam int B_POL  = 5;
   localparam int B_PDIS = 6;
   localparam int B_RSV  = 7;

   typedef struct packed {
      logic pull_dis;
      logic rise_pol;
      logic pin_en;
      logic irq_en;
      logic lvl_mode;
   } ctrl_t;

   // Active level of a sample under the chosen polarity
   function automatic logic level_active(input logic smp, input logic rise);
      return rise ? smp : ~smp;
   endfunction
endpackage

// File: rtl/extirq_sync.sv
`timescale 1ns/1ps
module extirq_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_in,
   output logic q_out
);
   localparam int LAST = STAGES - 1;

   logic [LAST:0] chain;

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("extirq_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= {STAGES{RST_VAL}};
      end else begin
         chain <= {chain[LAST-1:0], d_in};
      end
   end

   assign q_out = chain[LAST];
endmodule

// File: rtl/extirq_event.sv
`timescale 1ns/1ps
module extirq_event
   import extirq_pkg::*;
#(
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic smp,
   input  logic pin_en,
   input  logic rise_pol,
   input  logic lvl_mode,
   input  logic ack,
   output logic evt_set,
   output logic flag
);
   logic prev_q;
   logic now_act;
   logic prev_act;
   logic edge_hit;
   logic level_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= RST_VAL;
      end else begin
         prev_q <= smp;
      end
   end

   always_comb begin
      now_act   = level_active(smp, rise_pol);
      prev_act  = level_active(prev_q, rise_pol);
      edge_hit  = pin_en & now_act & ~prev_act;
      level_hit = pin_en & lvl_mode & now_act;
      evt_set   = edge_hit | level_hit;
   end

   // set has priority over acknowledge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag <= 1'b0;
      end else if (evt_set) begin
         flag <= 1'b1;
      end else if (ack) begin
         flag <= 1'b0;
      end
   end
endmodule

// File: rtl/extirq_regs.sv
`timescale 1ns/1ps
module extirq_regs
   import extirq_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [REG_W-1:0] wdata,
   input  logic             flag,
   output ctrl_t            ctrl,
   output logic             ack,
   output logic [REG_W-1:0] rdata,
   output logic             pull_up,
   output logic             pull_dn
);
   logic unused_wbits;
   logic pull_on;

   assign unused_wbits = ^{wdata[B_RSV], wdata[B_FLAG]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl <= '0;
      end else if (wr) begin
         ctrl.pull_dis <= wdata[B_PDIS];
         ctrl.rise_pol <= wdata[B_POL];
         ctrl.pin_en   <= wdata[B_PEN];
         ctrl.irq_en   <= wdata[B_IE];
         ctrl.lvl_mode <= wdata[B_MODE];
      end
   end

   assign ack = wr & wdata[B_ACK];

   always_comb begin
      rdata         = '0;
      rdata[B_PDIS] = ctrl.pull_dis;
      rdata[B_POL]  = ctrl.rise_pol;
      rdata[B_PEN]  = ctrl.pin_en;
      rdata[B_FLAG] = flag;
      rdata[B_IE]   = ctrl.irq_en;
      rdata[B_MODE] = ctrl.lvl_mode;
   end

   assign pull_on = ctrl.pin_en & ~ctrl.pull_dis;
   assign pull_up = pull_on & ~ctrl.rise_pol;
   assign pull_dn = pull_on & ctrl.rise_pol;
endmodule

// File: rtl/extirq_detect.sv
`timescale 1ns/1ps
module extirq_detect
   import extirq_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pin_in,
   input  logic             reg_wr,
   input  logic [REG_W-1:0] reg_wdata,
   output logic [REG_W-1:0] reg_rdata,
   output logic             irq_req,
   output logic             pull_up_en,
   output logic             pull_dn_en
);
   localparam logic SMP_RST = 1'b0;

   ctrl_t ctrl;
   logic  smp;
   logic  ack;
   logic  evt_set;
   logic  flag;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("extirq_detect: SYNC_STAGES must be at least 2");
      end
   endgenerate

   extirq_sync #(
      .STAGES  (SYNC_STAGES),
      .RST_VAL (SMP_RST)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (pin_in),
      .q_out (smp)
   );

   extirq_event #(
      .RST_VAL (SMP_RST)
   ) u_event (
      .clk      (clk),
      .rst_n    (rst_n),
      .smp      (smp),
      .pin_en   (ctrl.pin_en),
      .rise_pol (ctrl.rise_pol),
      .lvl_mode (ctrl.lvl_mode),
      .ack      (ack),
      .evt_set  (evt_set),
      .flag     (flag)
   );

   extirq_regs u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (reg_wr),
      .wdata   (reg_wdata),
      .flag    (flag),
      .ctrl    (ctrl),
      .ack     (ack),
      .rdata   (reg_rdata),
      .pull_up (pull_up_en),
      .pull_dn (pull_dn_en)
   );

   assign irq_req = flag & ctrl.irq_en;
endmodule

// File: rtl/extirq_detect_chk.sv
`timescale 1ns/1ps
module extirq_detect_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       ack_wr,
   input logic [7:0] reg_rdata,
   input logic       irq_req,
   input logic       pull_up_en,
   input logic       pull_dn_en,
   input logic       evt_set
);
   logic unused_chk;
   assign unused_chk = reg_rdata[0];

   a_r2_fixed_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rdata[7] == 1'b0) && (reg_rdata[2] == 1'b0));

   a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_wr && !evt_set) |=> !reg_rdata[3]);

   a_r7_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rdata[3] && !ack_wr) |=> reg_rdata[3]);

   a_r8_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
      evt_set |=> reg_rdata[3]);

   a_r9_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req == (reg_rdata[3] && reg_rdata[1]));

   a_r10_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(reg_rdata[3]) |-> $past(reg_rdata[4]));

   a_r11_pull_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(pull_up_en && pull_dn_en));

   a_r11_pull_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (pull_up_en || pull_dn_en) |-> (reg_rdata[4] && !reg_rdata[6]));

   a_r11_pull_dir: assert property (@(posedge clk) disable iff (!rst_n)
      pull_dn_en |-> reg_rdata[5]);
endmodule

bind extirq_detect extirq_detect_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ack_wr     (reg_wr && reg_wdata[2]),
   .reg_rdata  (reg_rdata),
   .irq_req    (irq_req),
   .pull_up_en (pull_up_en),
   .pull_dn_en (pull_dn_en),
   .evt_set    (evt_set)
);

// File: tb/extirq_detect_tb.sv
`timescale 1ns/1ps
module extirq_detect_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pin_in = 1'b1;
   logic       reg_wr = 1'b0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic       irq_req;
   logic       pull_up_en;
   logic       pull_dn_en;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // reference model state
   logic m_s1, m_s2, m_p, m_flag;
   logic m_pd, m_pol, m_en, m_ie, m_mode;

   always #2 clk = ~clk;

   extirq_detect u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .pin_in     (pin_in),
      .reg_wr     (reg_wr),
      .reg_wdata  (reg_wdata),
      .reg_rdata  (reg_rdata),
      .irq_req    (irq_req),
      .pull_up_en (pull_up_en),
      .pull_dn_en (pull_dn_en)
   );

   function automatic logic act(input logic v, input logic rise);
      return rise ? v : ~v;
   endfunction

   function automatic logic [7:0] exp_rdata();
      return {1'b0, m_pd, m_pol, m_en, m_flag, 1'b0, m_ie, m_mode};
   endfunction

   function automatic logic [2:0] exp_misc();
      // {irq, pull_up, pull_dn}
      return {m_flag & m_ie, m_en & ~m_pd & ~m_pol, m_en & ~m_pd & m_pol};
   endfunction

   task automatic chk(input string tag, input logic [7:0] act_v, input logic [7:0] exp_v);
      checks++;
      if (act_v !== exp_v) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act_v, exp_v, $time);
      end
   endtask

   task automatic model_reset();
      m_s1 = 0; m_s2 = 0; m_p = 0; m_flag = 0;
      m_pd = 0; m_pol = 0; m_en = 0; m_ie = 0; m_mode = 0;
   endtask

   task automatic model_step(input logic pin, input logic wr, input logic [7:0] wd);
      logic ev;
      ev = (m_en & act(m_s2, m_pol) & ~act(m_p, m_pol)) | (m_en & m_mode & act(m_s2, m_pol));
      if (ev) m_flag = 1'b1;
      else if (wr & wd[2]) m_flag = 1'b0;
      m_p = m_s2; m_s2 = m_s1; m_s1 = pin;
      if (wr) begin
         m_pd = wd[6]; m_pol = wd[5]; m_en = wd[4]; m_ie = wd[1]; m_mode = wd[0];
      end
   endtask

   // One clock: drive at a falling edge, compare at the next falling edge
   task automatic cyc(input logic pin, input logic wr, input logic [7:0] wd);
      pin_in = pin; reg_wr = wr; reg_wdata = wd;
      model_step(pin, wr, wd);
      @(negedge clk);
      reg_wr = 1'b0;
      chk("R2 model rdata", reg_rdata, exp_rdata());
      chk("R9 R11 model irq/pulls", {5'd0, irq_req, pull_up_en, pull_dn_en}, {5'd0, exp_misc()});
   endtask

   task automatic idle(input logic pin, input int n);
      for (int i = 0; i < n; i++) cyc(pin, 1'b0, 8'h00);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int seed;
      seed = 32'h5eed_1234;
      void'($urandom(seed));
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 rdata", reg_rdata, 8'h00);
      chk("R1 irq/pulls", {5'd0, irq_req, pull_up_en, pull_dn_en}, 8'h00);

      // falling, edge mode, enabled, irq enabled
      cyc(1, 1, 8'h12);
      idle(1, 3);
      // R3 latency: flag after third edge
      cyc(0, 0, 8'h00);
      cyc(0, 0, 8'h00);
      chk("R3 flag not yet", {7'd0, reg_rdata[3]}, 8'h00);
      cyc(0, 0, 8'h00);
      chk("R3 flag after three edges", {7'd0, reg_rdata[3]}, 8'h01);
      chk("R9 irq with flag and enable", {7'd0, irq_req}, 8'h01);
      // R7 zero in ack bit keeps flag
      cyc(0, 1, 8'h12);
      chk("R7 ack zero no effect", {7'd0, reg_rdata[3]}, 8'h01);
      cyc(0, 1, 8'h16);
      chk("R7 ack clears", {7'd0, reg_rdata[3]}, 8'h00);
      idle(0, 3);
      chk("R5 held level ignored", {7'd0, reg_rdata[3]}, 8'h00);

      // R8 edge and ack in the same cycle
      idle(1, 4);
      chk("R4 rising ignored under falling", {7'd0, reg_rdata[3]}, 8'h00);
      cyc(0, 0, 8'h00);
      cyc(0, 0, 8'h00);
      cyc(0, 1, 8'h16);
      chk("R8 event beats ack", {7'd0, reg_rdata[3]}, 8'h01);
      cyc(0, 1, 8'h16);
      chk("R7 ack clears after collision", {7'd0, reg_rdata[3]}, 8'h00);

      // R6 level mode, falling polarity, pin low
      cyc(0, 1, 8'h13);
      cyc(0, 0, 8'h00);
      chk("R6 low level sets", {7'd0, reg_rdata[3]}, 8'h01);
      cyc(0, 1, 8'h17);
      chk("R6 ack blocked while active", {7'd0, reg_rdata[3]}, 8'h01);
      cyc(1, 0, 8'h00);
      cyc(1, 0, 8'h00);
      cyc(1, 1, 8'h17);
      chk("R6 ack works after release", {7'd0, reg_rdata[3]}, 8'h00);

      // R4 rising polarity, edge mode
      cyc(1, 1, 8'h32);
      idle(1, 2);
      chk("R4 no event when idle", {7'd0, reg_rdata[3]}, 8'h00);
      idle(0, 3);
      chk("R4 falling ignored under rising", {7'd0, reg_rdata[3]}, 8'h00);
      idle(1, 3);
      chk("R4 rising detected", {7'd0, reg_rdata[3]}, 8'h01);
      cyc(1, 1, 8'h36);
      chk("R7 ack clears rising", {7'd0, reg_rdata[3]}, 8'h00);

      // R11 pulls
      chk("R11 pull-down under rising", {6'd0, pull_up_en, pull_dn_en}, 8'h01);
      cyc(1, 1, 8'h72);
      chk("R11 pull disabled", {6'd0, pull_up_en, pull_dn_en}, 8'h00);
      cyc(1, 1, 8'h12);
      chk("R11 pull-up under falling", {6'd0, pull_up_en, pull_dn_en}, 8'h02);
      cyc(1, 1, 8'h02);
      chk("R11 no pull when pin off", {6'd0, pull_up_en, pull_dn_en}, 8'h00);

      // R10 pin disabled
      idle(0, 3);
      idle(1, 3);
      cyc(0, 1, 8'h03);
      idle(0, 4);
      chk("R10 no event when disabled", {7'd0, reg_rdata[3]}, 8'h00);
      chk("R9 irq low without flag", {7'd0, irq_req}, 8'h00);

      // R2 write all ones
      cyc(0, 1, 8'hFF);
      chk("R2 all-ones write", reg_rdata, 8'h73);

      // random phase
      begin
         logic pin;
         pin = 1'b0;
         for (int i = 0; i < 6000; i++) begin
            logic       wr;
            logic [7:0] wd;
            if ($urandom_range(0, 5) == 0) pin = ~pin;
            wr = ($urandom_range(0, 7) == 0);
            wd = 8'($urandom());
            cyc(pin, wr, wd);
         end
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule